// File: doc/BRIEF.md
# Configurable DRAM Address Decoder

This block turns a physical byte address into six memory coordinates: row, column, bank, rank, channel and subarray. It first discards the byte offset inside one bus word and the low column bits that a single burst already covers. It then splits the remaining address into fields, starting at the least significant end, in an order that a run-time order word selects.

Every field holds a power-of-two number of entries and is sized as a bit count. Each modulo and divide step is therefore a mask and a shift. The subarray width is not set directly: it is the row width minus the mat-height width, which gives one subarray when the mat height equals the row count.

A memory controller puts the decoder in front of its request queues. One address can enter in every cycle, and the decoded set appears, qualified by a valid bit, one cycle after it.

Top module: `dram_addr_decoder`

## Requirements
- R1: Address bits below BUS_BYTES_LOG2 + BURST_LEN_LOG2 (byte offset within a bus word, then the burst's low column bits) have no effect on any decoded field.
- R2: `cfg_order` holds six 3-bit slot codes, slot k at bits [3k+2:3k]. Slot 0 takes the least significant bits of the remaining address. The codes are row=0, column=1, bank=2, rank=3, channel=4, subarray=5.
- R3: For each slot in turn, its field equals the remaining address modulo 2^bits. The remaining address is then divided by 2^bits before the next slot is taken.
- R4: The subarray field width is row bits minus mat bits. It is zero, giving a subarray field of 0, when mat bits are greater than or equal to row bits.
- R5: `cfg_err` is 1 exactly when the six slot codes are not a permutation of 0..5, that is, some code is above 5 or is repeated. It is a combinational function of `cfg_order`.
- R6: `out_valid` is high in the cycle after each cycle with `in_valid` high, and addresses are accepted back to back with no gaps.
- R7: `out_valid` is 0 after reset. After a cycle with `in_valid` low, `out_valid` is 0 and every field keeps its value, whatever the address input carries.
- R8: No decoded field ever reaches 2 to the power of its configured bit count.
- R9: A field with a bit count of zero decodes to 0 and consumes no address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address qualifier |
| in_addr | input | ADDR_W | Physical byte address |
| cfg_order | input | 18 | Six 3-bit slot codes, slot 0 lowest |
| cfg_row_bits | input | BITS_W | log2 of rows per bank |
| cfg_col_bits | input | BITS_W | log2 of visible column groups |
| cfg_bank_bits | input | BITS_W | log2 of banks per rank |
| cfg_rank_bits | input | BITS_W | log2 of ranks per channel |
| cfg_chan_bits | input | BITS_W | log2 of channels |
| cfg_mat_bits | input | BITS_W | log2 of mat height in rows |
| cfg_err | output | 1 | Order word is not a permutation |
| out_valid | output | 1 | Decoded set is valid |
| out_row | output | FIELD_W | Row |
| out_col | output | FIELD_W | Column |
| out_bank | output | FIELD_W | Bank |
| out_rank | output | FIELD_W | Rank |
| out_chan | output | FIELD_W | Channel |
| out_sa | output | FIELD_W | Subarray |

## Verification
The fields and `out_valid` for an address are due at the first rising edge after that address is driven. The bench drives on the falling edge and compares the outputs at the next falling edge, half a period after the register that updates them. Because a new address is driven in that same step, every streaming cycle checks the previous address while presenting the next one. `cfg_err` has no register in its path, so it is compared a short delay after `cfg_order` changes, with no clock edge in between.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int CODE_W     = 3;
  localparam int ORDER_W    = NUM_FIELDS * CODE_W;

  typedef enum logic [CODE_W-1:0] {
    FLD_ROW  = 3'd0,
    FLD_COL  = 3'd1,
    FLD_BANK = 3'd2,
    FLD_RANK = 3'd3,
    FLD_CHAN = 3'd4,
    FLD_SA   = 3'd5
  } field_code_e;
endpackage

// File: rtl/addr_order_check.sv
module addr_order_check
  import addr_dec_pkg::*;
(
  input  logic [ORDER_W-1:0] order,
  output logic               err
);
  logic [NUM_FIELDS-1:0] seen;

  always_comb begin
    seen = '0;
    for (int k = 0; k < NUM_FIELDS; k++) begin
      for (int f = 0; f < NUM_FIELDS; f++) begin
        if (order[k*CODE_W +: CODE_W] == CODE_W'(f)) seen[f] = 1'b1;
      end
    end
    // six slots cover six codes only when each appears once
    err = ~&seen;
  end
endmodule

// File: rtl/addr_field_peel.sv
module addr_field_peel
  import addr_dec_pkg::*;
#(
  parameter int REM_W   = 26,
  parameter int FIELD_W = 16,
  parameter int BITS_W  = 5
) (
  input  logic [REM_W-1:0]                      rem_in,
  input  logic [ORDER_W-1:0]                    order,
  input  logic [NUM_FIELDS-1:0][BITS_W-1:0]     bits_by_code,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]    val_by_code
);
  logic [REM_W-1:0]   rem_s    [NUM_FIELDS+1];
  logic [FIELD_W-1:0] slot_val [NUM_FIELDS];
  logic [CODE_W-1:0]  slot_code[NUM_FIELDS];

  assign rem_s[0] = rem_in;

  genvar k;
  generate
    for (k = 0; k < NUM_FIELDS; k++) begin : g_slot
      logic [BITS_W-1:0] sh;
      logic [REM_W-1:0]  mask;
      logic [REM_W-1:0]  masked;

      assign slot_code[k] = order[k*CODE_W +: CODE_W];

      always_comb begin
        sh = '0;
        for (int f = 0; f < NUM_FIELDS; f++) begin
          if (slot_code[k] == CODE_W'(f)) sh = bits_by_code[f];
        end
      end

      assign mask          = ~({REM_W{1'b1}} << sh);
      assign masked        = rem_s[k] & mask;
      assign slot_val[k]   = masked[FIELD_W-1:0];
      assign rem_s[k+1]    = rem_s[k] >> sh;
    end
  endgenerate

  // route slot results to field codes; lowest slot wins on a repeated code
  always_comb begin
    val_by_code = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      for (int s = NUM_FIELDS - 1; s >= 0; s--) begin
        if (slot_code[s] == CODE_W'(f)) val_by_code[f] = slot_val[s];
      end
    end
  end

  logic unused_tail;
  assign unused_tail = ^rem_s[NUM_FIELDS];
endmodule

// File: rtl/dram_addr_decoder.sv
module dram_addr_decoder
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int BUS_BYTES_LOG2 = 3,
  parameter int BURST_LEN_LOG2 = 3,
  parameter int FIELD_W        = 16,
  localparam int BITS_W        = $clog2(FIELD_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [17:0]         cfg_order,
  input  logic [BITS_W-1:0]   cfg_row_bits,
  input  logic [BITS_W-1:0]   cfg_col_bits,
  input  logic [BITS_W-1:0]   cfg_bank_bits,
  input  logic [BITS_W-1:0]   cfg_rank_bits,
  input  logic [BITS_W-1:0]   cfg_chan_bits,
  input  logic [BITS_W-1:0]   cfg_mat_bits,
  output logic                cfg_err,
  output logic                out_valid,
  output logic [FIELD_W-1:0]  out_row,
  output logic [FIELD_W-1:0]  out_col,
  output logic [FIELD_W-1:0]  out_bank,
  output logic [FIELD_W-1:0]  out_rank,
  output logic [FIELD_W-1:0]  out_chan,
  output logic [FIELD_W-1:0]  out_sa
);
  localparam int DROP  = BUS_BYTES_LOG2 + BURST_LEN_LOG2;
  localparam int REM_W = ADDR_W - DROP;

  logic [REM_W-1:0]                   rem;
  logic [BITS_W-1:0]                  sa_bits;
  logic [NUM_FIELDS-1:0][BITS_W-1:0]  bits_by_code;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] val_by_code;
  logic                               valid_d;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fld_q;

  // R1: byte offset and burst column bits leave before decoding
  assign rem = in_addr[ADDR_W-1:DROP];
  logic unused_low;
  assign unused_low = ^in_addr[DROP-1:0];

  // R4: subarray count is rows over mat height
  assign sa_bits = (cfg_row_bits > cfg_mat_bits) ? (cfg_row_bits - cfg_mat_bits) : '0;

  always_comb begin
    bits_by_code           = '0;
    bits_by_code[FLD_ROW]  = cfg_row_bits;
    bits_by_code[FLD_COL]  = cfg_col_bits;
    bits_by_code[FLD_BANK] = cfg_bank_bits;
    bits_by_code[FLD_RANK] = cfg_rank_bits;
    bits_by_code[FLD_CHAN] = cfg_chan_bits;
    bits_by_code[FLD_SA]   = sa_bits;
  end

  addr_order_check u_order_check (
    .order (cfg_order),
    .err   (cfg_err)
  );

  addr_field_peel #(
    .REM_W   (REM_W),
    .FIELD_W (FIELD_W),
    .BITS_W  (BITS_W)
  ) u_peel (
    .rem_in       (rem),
    .order        (cfg_order),
    .bits_by_code (bits_by_code),
    .val_by_code  (val_by_code)
  );

  // next state
  assign valid_d = in_valid;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) fld_q <= val_by_code;
  end

  assign out_row  = fld_q[FLD_ROW];
  assign out_col  = fld_q[FLD_COL];
  assign out_bank = fld_q[FLD_BANK];
  assign out_rank = fld_q[FLD_RANK];
  assign out_chan = fld_q[FLD_CHAN];
  assign out_sa   = fld_q[FLD_SA];

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_valid) |=> (!out_valid && $stable(out_row) && $stable(out_col)
                                  && $stable(out_bank) && $stable(out_sa)));

  a_r8_field_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((out_row  >> $past(cfg_row_bits))  == '0) &&
                  ((out_col  >> $past(cfg_col_bits))  == '0) &&
                  ((out_bank >> $past(cfg_bank_bits)) == '0) &&
                  ((out_rank >> $past(cfg_rank_bits)) == '0) &&
                  ((out_chan >> $past(cfg_chan_bits)) == '0)));

  a_r4_single_subarray: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (cfg_mat_bits >= cfg_row_bits)) |=> (out_sa == '0));
endmodule

// File: tb/tb_dram_addr_decoder.sv
module tb_dram_addr_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int BB  = 1;
  localparam int BL  = 1;
  localparam int FW  = 4;
  localparam int BW  = $clog2(FW + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [AW-1:0] in_addr;
  logic [17:0]   cfg_order;
  logic [BW-1:0] cfg_row_bits, cfg_col_bits, cfg_bank_bits;
  logic [BW-1:0] cfg_rank_bits, cfg_chan_bits, cfg_mat_bits;
  logic          cfg_err, out_valid;
  logic [FW-1:0] out_row, out_col, out_bank, out_rank, out_chan, out_sa;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_addr_decoder #(
    .ADDR_W(AW), .BUS_BYTES_LOG2(BB), .BURST_LEN_LOG2(BL), .FIELD_W(FW)
  ) dut (
    .clk, .rst_n, .in_valid, .in_addr, .cfg_order,
    .cfg_row_bits, .cfg_col_bits, .cfg_bank_bits,
    .cfg_rank_bits, .cfg_chan_bits, .cfg_mat_bits,
    .cfg_err, .out_valid,
    .out_row, .out_col, .out_bank, .out_rank, .out_chan, .out_sa
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // arithmetic reference: divide and modulo by powers of two
  function automatic logic [23:0] model(input int addr);
    int rem, bits[6], fld[6], sb;
    bit taken[6];
    sb = (cfg_row_bits > cfg_mat_bits) ? int'(cfg_row_bits) - int'(cfg_mat_bits) : 0;
    bits[0] = cfg_row_bits;  bits[1] = cfg_col_bits; bits[2] = cfg_bank_bits;
    bits[3] = cfg_rank_bits; bits[4] = cfg_chan_bits; bits[5] = sb;
    for (int f = 0; f < 6; f++) begin fld[f] = 0; taken[f] = 0; end
    rem = addr / (2 ** (BB + BL));
    for (int s = 0; s < 6; s++) begin
      int c;
      c = int'(cfg_order[3*s +: 3]);
      if (c < 6) begin
        if (!taken[c]) fld[c] = rem % (2 ** bits[c]);
        taken[c] = 1;
        rem = rem / (2 ** bits[c]);
      end
    end
    return {fld[0][3:0], fld[1][3:0], fld[2][3:0], fld[3][3:0], fld[4][3:0], fld[5][3:0]};
  endfunction

  function automatic logic [23:0] outs();
    return {out_row, out_col, out_bank, out_rank, out_chan, out_sa};
  endfunction

  task automatic set_cfg(input logic [17:0] ord, input int r, input int c, input int b,
                         input int k, input int ch, input int m);
    cfg_order = ord;
    cfg_row_bits = BW'(r); cfg_col_bits = BW'(c); cfg_bank_bits = BW'(b);
    cfg_rank_bits = BW'(k); cfg_chan_bits = BW'(ch); cfg_mat_bits = BW'(m);
  endtask

  // full address sweep, back to back; each result due one edge later
  task automatic sweep(input string req);
    for (int a = 0; a < (1 << AW); a++) begin
      in_valid = 1'b1;
      in_addr  = AW'(a);
      @(negedge clk);
      check(out_valid == 1'b1, "R6 valid", out_valid, 1);
      check(outs() == model(a), req, outs(), model(a));
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_cmp, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] held;
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0;
    set_cfg({3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 3, 2, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 idle after reset", out_valid, 0);

    // R5 combinational permutation check
    #1 check(cfg_err == 1'b0, "R5 identity order", cfg_err, 0);
    cfg_order = {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5};
    #1 check(cfg_err == 1'b0, "R5 reversed order", cfg_err, 0);
    cfg_order = {3'd0,3'd1,3'd2,3'd3,3'd4,3'd4};
    #1 check(cfg_err == 1'b1, "R5 repeated code", cfg_err, 1);
    cfg_order = {3'd7,3'd1,3'd2,3'd3,3'd4,3'd5};
    #1 check(cfg_err == 1'b1, "R5 code above five", cfg_err, 1);

    // R2 R3 identity order, four subarrays from mat bits
    set_cfg({3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 3, 2, 1, 1, 1, 1);
    @(negedge clk);
    sweep("R3 identity order fields");

    // R2 R4 reversed order, mat height covers all rows
    set_cfg({3'd0,3'd1,3'd2,3'd3,3'd4,3'd5}, 2, 3, 2, 1, 1, 3);
    @(negedge clk);
    sweep("R4 reversed order, one subarray");

    // R9 mixed order, zero-width column field
    set_cfg({3'd3,3'd4,3'd1,3'd5,3'd0,3'd2}, 4, 0, 2, 1, 1, 2);
    @(negedge clk);
    sweep("R9 mixed order, empty column");

    // R1 low bits ignored
    for (int lo = 0; lo < (1 << (BB + BL)); lo++) begin
      in_valid = 1'b1;
      in_addr  = AW'(12'hA50 | lo);
      @(negedge clk);
      check(outs() == model(12'hA50), "R1 low bits ignored", outs(), model(12'hA50));
    end

    // R7 hold while idle
    held = outs();
    in_valid = 1'b0;
    in_addr  = 12'h3C7;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 valid drops", out_valid, 0);
    check(outs() == held, "R7 fields hold", outs(), held);
    in_addr = 12'hFFF;
    @(negedge clk);
    check(outs() == held, "R7 fields hold again", outs(), held);

    // R6 alternating pattern
    for (int i = 0; i < 8; i++) begin
      in_valid = i[0];
      in_addr  = AW'(i * 299);
      @(negedge clk);
      check(out_valid == i[0], "R6 alternating valid", out_valid, i[0]);
      if (i[0]) check(outs() == model(i * 299), "R8 decoded in gaps", outs(), model(i * 299));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule